// File: doc/BRIEF.md
# Fast Interrupt Source Unit

This block conditions one dedicated fast interrupt input and turns it into an active-low request line for a processor. It applies no priority arbitration. The raw input is first brought into the local clock domain by a two-flop synchronizer. It is then interpreted as a level or an edge, according to a programmable trigger type. An enable mask gates the result before it drives the request pin.

Software reaches the block over a simple word-indexed register bus. The registers are a mode word, a handler-address word and a pair of enable and disable command words. There is also a read-only mask word and a fast-vector word. A read of the fast-vector word returns the stored handler address, so a single load can branch straight to the handler. In the edge trigger types, the same read also acknowledges the pending event. The priority field in the mode word is kept only so that software can read back what it wrote.

Register word indices: 0 mode, 1 handler address, 2 enable command, 3 disable command, 4 mask (read-only), 5 fast vector (read-only, with side effect). In the mode word, bits [1:0] hold the trigger type and bits [6:4] hold the priority field. Read data is registered and appears on the clock edge that samples the read strobe.

Top module: `fast_irq_unit`

## Requirements
- R1: After reset, fast_req_n is high and the mode, handler-address and mask words all read back as zero.
- R2: A write to the enable command word with bit 0 set makes mask bit 0 read 1. A write to either command word with bit 0 clear leaves the mask unchanged.
- R3: A write to the disable command word with bit 0 set makes mask bit 0 read 0 and holds fast_req_n high. A pending edge event survives this and drives fast_req_n low again once the source is re-enabled.
- R4: With trigger type 2'b10 (high level), fast_req_n is low exactly while the synchronized input is high and the source is enabled.
- R5: With trigger type 2'b00 (low level), fast_req_n is low exactly while the synchronized input is low and the source is enabled.
- R6: With trigger type 2'b11 (rising edge), a 0-to-1 input transition latches a pending event that keeps fast_req_n low after the input returns to 0.
- R7: With trigger type 2'b01 (falling edge), a 1-to-0 input transition latches a pending event, and a 0-to-1 transition does not.
- R8: A read of the fast-vector word returns the handler-address word. In an edge trigger type it clears the pending event, so fast_req_n returns high.
- R9: A read of the fast-vector word in a level trigger type leaves the request unchanged while the active level persists.
- R10: An edge detected in the same cycle as a clearing fast-vector read stays pending.
- R11: The priority field (mode bits [6:4]) reads back as written and has no effect on the request.
- R12: A level change at src_in reaches fast_req_n after two rising clock edges, not after one, because it passes through the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 1 | Asynchronous fast interrupt source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| fast_req_n | output | 1 | Active-low fast interrupt request |

## Verification
The assertions assume that a write and a read never target the same word in one cycle. They also assume that reset is held for at least one clock edge before any bus traffic, so the synchronizer and edge history start from known zeros. The stimulus drives every bus strobe and src_in on falling clock edges, issues one bus operation at a time, and starts with reset asserted and src_in low. Between table rows the bench lets the input settle for several cycles, and it clears any leftover edge event with a fast-vector read before it applies a new transition.

// File: rtl/fastirq_pkg.sv
package fastirq_pkg;

    // Trigger type encoding: bit 0 selects edge mode, bit 1 selects the active polarity.
    typedef enum logic [1:0] {
        TRIG_LOW_LVL  = 2'b00,
        TRIG_FALL     = 2'b01,
        TRIG_HIGH_LVL = 2'b10,
        TRIG_RISE     = 2'b11
    } trig_e;

    localparam int REG_IDX_W = 3;
    localparam int PRIO_W    = 3;
    localparam int TRIG_LSB  = 0;
    localparam int PRIO_LSB  = 4;

    typedef enum logic [REG_IDX_W-1:0] {
        RA_MODE    = 3'd0,
        RA_VECTOR  = 3'd1,
        RA_ENABLE  = 3'd2,
        RA_DISABLE = 3'd3,
        RA_MASK    = 3'd4,
        RA_FVEC    = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        trig_e             trig;
    } mode_t;

    function automatic logic trig_is_edge(input trig_e t);
        return t[0];
    endfunction

    function automatic logic trig_active_high(input trig_e t);
        return t[1];
    endfunction

endpackage

// File: rtl/fastirq_sync.sv
module fastirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("fastirq_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

    // The last stage follows the one before it by exactly one cycle.
    assert_sync_shift_R12: assert property (@(posedge clk) disable iff (rst)
        dout == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/fastirq_cond.sv
module fastirq_cond
    import fastirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_sync,
    input  trig_e trig,
    input  logic  vec_rd,
    output logic  pend
);

    logic  prev_q;
    logic  edge_pend_q;
    logic  edge_mode;
    logic  act_high;
    logic  rise;
    logic  fall;
    logic  det;
    logic  clr;
    logic  level_pend;

    assign edge_mode = trig_is_edge(trig);
    assign act_high  = trig_active_high(trig);
    assign rise      = src_sync & ~prev_q;
    assign fall      = ~src_sync & prev_q;
    assign det       = edge_mode & (act_high ? rise : fall);
    assign clr       = edge_mode & vec_rd;
    assign level_pend = act_high ? src_sync : ~src_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= 1'b0;
            edge_pend_q <= 1'b0;
        end else begin
            prev_q <= src_sync;
            if (!edge_mode) begin
                edge_pend_q <= 1'b0;
            end else begin
                // A new edge wins over an acknowledge in the same cycle.
                edge_pend_q <= (edge_pend_q & ~clr) | det;
            end
        end
    end

    assign pend = edge_mode ? edge_pend_q : level_pend;

    assert_edge_kept_R10: assert property (@(posedge clk) disable iff (rst)
        det |=> edge_pend_q);

    assert_edge_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !det) |=> !edge_pend_q);

    assert_edge_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && edge_pend_q && !vec_rd && $stable(trig)) |=> edge_pend_q);

endmodule

// File: rtl/fastirq_regs.sv
module fastirq_regs
    import fastirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output trig_e                trig,
    output logic                 enabled,
    output logic                 vec_rd
);

    mode_t             mode_q;
    logic [DATA_W-1:0] vec_q;
    logic              en_q;
    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] mask_word;

    always_comb begin
        mode_word = '0;
        mode_word[TRIG_LSB +: 2]      = mode_q.trig;
        mode_word[PRIO_LSB +: PRIO_W] = mode_q.prio;
        mask_word    = '0;
        mask_word[0] = en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{prio: '0, trig: TRIG_LOW_LVL};
            vec_q  <= '0;
            en_q   <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                RA_MODE: begin
                    mode_q.trig <= trig_e'(bus_wdata[TRIG_LSB +: 2]);
                    mode_q.prio <= bus_wdata[PRIO_LSB +: PRIO_W];
                end
                RA_VECTOR:  vec_q <= bus_wdata;
                RA_ENABLE:  if (bus_wdata[0]) en_q <= 1'b1;
                RA_DISABLE: if (bus_wdata[0]) en_q <= 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                RA_MODE:   bus_rdata <= mode_word;
                RA_VECTOR: bus_rdata <= vec_q;
                RA_MASK:   bus_rdata <= mask_word;
                RA_FVEC:   bus_rdata <= vec_q;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assign trig    = mode_q.trig;
    assign enabled = en_q;
    assign vec_rd  = bus_rd && (bus_addr == RA_FVEC);

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_ENABLE && bus_wdata[0]) |=> en_q);

    assert_mask_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_DISABLE && bus_wdata[0]) |=> !en_q);

    assert_mask_inert_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == RA_ENABLE || bus_addr == RA_DISABLE) && bus_wdata[0])
        |=> $stable(en_q));

    assert_fvec_data_R8: assert property (@(posedge clk) disable iff (rst)
        vec_rd |=> (bus_rdata == $past(vec_q)));

endmodule

// File: rtl/fast_irq_unit.sv
module fast_irq_unit
    import fastirq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 fast_req_n
);

    logic  src_sync;
    trig_e trig;
    logic  enabled;
    logic  vec_rd;
    logic  pend;

    fastirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (src_in),
        .dout (src_sync)
    );

    fastirq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trig      (trig),
        .enabled   (enabled),
        .vec_rd    (vec_rd)
    );

    fastirq_cond u_cond (
        .clk      (clk),
        .rst      (rst),
        .src_sync (src_sync),
        .trig     (trig),
        .vec_rd   (vec_rd),
        .pend     (pend)
    );

    assign fast_req_n = ~(pend & enabled);

    // A level source whose synchronized input sits at its active level is requesting.
    assert_level_req_R4: assert property (@(posedge clk) disable iff (rst)
        (enabled && trig == TRIG_HIGH_LVL && src_sync) |-> !fast_req_n);

    assert_level_req_R5: assert property (@(posedge clk) disable iff (rst)
        (enabled && trig == TRIG_LOW_LVL && !src_sync) |-> !fast_req_n);

endmodule

// File: tb/fast_irq_unit_tb.sv
`timescale 1ns/1ps
module fast_irq_unit_tb;
    import fastirq_pkg::*;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              src_in = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              fast_req_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fast_irq_unit #(.DATA_W(DATA_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .src_in     (src_in),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fast_req_n (fast_req_n)
    );

    // Row: {trigger type[1:0], input before, input after, expected fast_req_n}
    localparam logic [4:0] TBL [12] = '{
        {2'b10, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b1, 1'b1},
        {2'b00, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input logic ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [DATA_W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [DATA_W-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic string type_tag(input logic [1:0] t);
        case (t)
            2'b10:   return "R4 high level";
            2'b00:   return "R5 low level";
            2'b11:   return "R6 rising edge";
            default: return "R7 falling edge";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        fails++;
        tests++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(fast_req_n == 1'b1, "R1 request idle", 32'(fast_req_n), 32'd1);
        bus_read(RA_MASK, rd);   check(rd == 0, "R1 mask", rd, 0);
        bus_read(RA_MODE, rd);   check(rd == 0, "R1 mode", rd, 0);
        bus_read(RA_VECTOR, rd); check(rd == 0, "R1 vector", rd, 0);

        // R2: enable command, and command words with bit 0 clear are inert
        bus_write(RA_ENABLE, 32'hFFFF_FFFE);
        bus_read(RA_MASK, rd); check(rd == 0, "R2 enable without bit0", rd, 0);
        bus_write(RA_ENABLE, 32'h1);
        bus_read(RA_MASK, rd); check(rd == 1, "R2 enable", rd, 1);
        bus_write(RA_DISABLE, 32'h2);
        bus_read(RA_MASK, rd); check(rd == 1, "R2 disable without bit0", rd, 1);

        // Table walk over trigger types (R4..R7), source enabled
        bus_write(RA_VECTOR, 32'hCAFE_0100);
        for (int i = 0; i < 12; i++) begin
            bus_write(RA_MODE, {30'd0, TBL[i][4:3]});
            src_in = TBL[i][2];
            repeat (5) @(negedge clk);
            bus_read(RA_FVEC, rd);
            src_in = TBL[i][1];
            repeat (5) @(negedge clk);
            check(fast_req_n == TBL[i][0], type_tag(TBL[i][4:3]),
                  32'(fast_req_n), 32'(TBL[i][0]));
        end

        // R12: synchronizer latency in high-level mode
        bus_write(RA_MODE, 32'h2);
        src_in = 1'b0;
        repeat (5) @(negedge clk);
        src_in = 1'b1;
        @(negedge clk);
        check(fast_req_n == 1'b1, "R12 one edge", 32'(fast_req_n), 32'd1);
        @(negedge clk);
        check(fast_req_n == 1'b0, "R12 two edges", 32'(fast_req_n), 32'd0);

        // R9: vector read in level mode keeps the request
        bus_read(RA_FVEC, rd);
        check(rd == 32'hCAFE_0100, "R8 vector value", rd, 32'hCAFE_0100);
        @(negedge clk);
        check(fast_req_n == 1'b0, "R9 level kept", 32'(fast_req_n), 32'd0);

        // R11: priority field read back, no effect
        bus_write(RA_MODE, 32'h72);
        bus_read(RA_MODE, rd); check(rd == 32'h72, "R11 readback", rd, 32'h72);
        @(negedge clk);
        check(fast_req_n == 1'b0, "R11 no effect", 32'(fast_req_n), 32'd0);

        // R8: rising edge pending cleared by vector read
        src_in = 1'b0;
        bus_write(RA_MODE, 32'h3);
        repeat (5) @(negedge clk);
        src_in = 1'b1;
        repeat (5) @(negedge clk);
        src_in = 1'b0;
        repeat (5) @(negedge clk);
        check(fast_req_n == 1'b0, "R6 latched", 32'(fast_req_n), 32'd0);
        bus_read(RA_FVEC, rd);
        check(rd == 32'hCAFE_0100, "R8 vector value edge", rd, 32'hCAFE_0100);
        check(fast_req_n == 1'b1, "R8 edge cleared", 32'(fast_req_n), 32'd1);

        // R3: disable masks, pending survives re-enable
        bus_write(RA_DISABLE, 32'h1);
        bus_read(RA_MASK, rd); check(rd == 0, "R3 mask cleared", rd, 0);
        src_in = 1'b1;
        repeat (5) @(negedge clk);
        check(fast_req_n == 1'b1, "R3 masked", 32'(fast_req_n), 32'd1);
        src_in = 1'b0;
        repeat (3) @(negedge clk);
        bus_write(RA_ENABLE, 32'h1);
        check(fast_req_n == 1'b0, "R3 pending kept", 32'(fast_req_n), 32'd0);

        // R10: new rising edge coincident with clearing read (pending already set)
        repeat (3) @(negedge clk);
        src_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_read(RA_FVEC, rd);
        check(fast_req_n == 1'b0, "R10 coincident edge kept", 32'(fast_req_n), 32'd0);
        bus_read(RA_FVEC, rd);
        check(fast_req_n == 1'b1, "R10 later read clears", 32'(fast_req_n), 32'd1);

        finish_run();
    end

endmodule